// File: doc/BRIEF.md
# Flash Write-Protection Guard

This block stands between the host bus strobes of a parallel NOR-flash device and its command state machine. It decides, clock by clock, whether the host is performing a genuine write cycle. It also decides whether a program or erase operation that the command decoder has assembled may proceed on the sector it targets. The raw active-low strobes are first cleaned by a per-strobe glitch filter. A write is then qualified against the supply-good flag and a power-up inhibit. The resulting write strobe produces one-cycle pulses at its start, for latching address and data, and at its end, for issuing the command.

A supply-low condition holds the command state machine in reset, so that it restarts in read-array mode. Each sector carries a stored protect bit. A flag that signals a high voltage held on the reset pin temporarily overrides protection for as long as it is asserted. It never alters the stored bits, which stay readable through an identification query port. An operation that is refused is rejected with a one-cycle pulse that sends the command state machine back to read-array mode.

Top module: `flash_wp_guard`

## Requirements
- R1: After filtering, the write strobe `wr_strobe` is high only while chip enable is low, write enable is low and output enable is high, with the supply good and no power-up inhibit pending. Any other strobe combination keeps it low.
- R2: Each raw strobe passes through a filter. A level change reaches the filtered strobe only after it has been sampled on `FILT_CYC` consecutive clock edges. A pulse of `FILT_CYC-1` samples has no effect on `wr_strobe`.
- R3: A one-cycle `wr_fall` pulse marks the cycle in which `wr_strobe` rises. A one-cycle `wr_rise` pulse marks the cycle in which it falls while the supply is good.
- R4: While `vcc_ok` is low, `wr_strobe` is low, no `wr_rise` is issued, and `csm_reset` is high one cycle later.
- R5: After `vcc_ok` rises, writes stay blocked until filtered write enable has been seen high at least once. A write already asserted at power-up therefore issues no command.
- R6: During and directly after reset, `csm_reset` is high (read-array mode) and `wr_strobe`, `op_grant` and `op_reject` are low.
- R7: One cycle after an `op_req`, `op_grant` pulses if the target sector's protect bit is 0 or `hv_unlock` is high. Otherwise `op_reject` pulses, which returns the command state machine to read-array mode.
- R8: `id_prot` always reports the stored protect bit of sector `id_sector`, whatever the state of `hv_unlock`. Once `hv_unlock` drops, protected sectors are rejected again.
- R9: While `vcc_ok` is low, an `op_req` produces neither `op_grant` nor `op_reject`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Raw chip enable, active low |
| we_n | input | 1 | Raw write enable, active low |
| oe_n | input | 1 | Raw output enable, active low |
| vcc_ok | input | 1 | Supply above lockout level |
| hv_unlock | input | 1 | High voltage held on reset pin: protection override |
| op_req | input | 1 | One-cycle program/erase request from command decoder |
| op_sector | input | SECT_W | Sector targeted by the request |
| prot_bits | input | NUM_SECT | Stored protect bit per sector, 1 = protected |
| id_sector | input | SECT_W | Sector queried in identification mode |
| wr_strobe | output | 1 | Qualified write cycle active |
| wr_fall | output | 1 | Pulse: latch address and data |
| wr_rise | output | 1 | Pulse: issue command |
| csm_reset | output | 1 | Holds command state machine in reset / read-array |
| op_grant | output | 1 | Pulse: operation permitted |
| op_reject | output | 1 | Pulse: operation refused, back to read-array |
| id_prot | output | 1 | Stored protect status of `id_sector` |

## Verification
The bench drives strobe pulses one sample shorter than the filter window and exactly as long as it. A filter off by one would start a write on the short pulse or miss the long one. It drops the supply in the middle of a write and later releases write enable. A guard that ignores the supply would emit a command pulse there. It also raises the supply with a write already asserted, where a missing power-up inhibit shows up as an unwanted command. Protected-sector requests are made with the override on, then off again. A design that cleared the stored bit under override, or that latched the override, would grant the second request or misreport `id_prot`.

// File: rtl/fwg_pkg.sv
package fwg_pkg;

    typedef struct packed {
        logic wr;
        logic fall;
        logic rise;
        logic inh;
        logic csm_rst;
        logic grant;
        logic reject;
    } guard_state_t;

    localparam guard_state_t GUARD_RESET = '{
        wr: 1'b0, fall: 1'b0, rise: 1'b0, inh: 1'b1,
        csm_rst: 1'b1, grant: 1'b0, reject: 1'b0
    };

endpackage

// File: rtl/fwg_deglitch.sv
module fwg_deglitch #(
    parameter int   FILT_CYC = 3,
    parameter logic IDLE_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic filt_o
);
    localparam int CNT_W = $clog2(FILT_CYC + 1);

    typedef struct packed {
        logic             lvl;
        logic [CNT_W-1:0] cnt;
    } filt_state_t;

    filt_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (raw_i == st_q.lvl) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == CNT_W'(FILT_CYC - 1)) begin
            st_d.lvl = raw_i;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lvl <= IDLE_VAL;
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign filt_o = st_q.lvl;
endmodule

// File: rtl/fwg_sector_gate.sv
module fwg_sector_gate #(
    parameter int NUM_SECT = 8,
    localparam int SECT_W  = $clog2(NUM_SECT)
) (
    input  logic [NUM_SECT-1:0] prot_bits,
    input  logic [SECT_W-1:0]   op_sector,
    input  logic [SECT_W-1:0]   id_sector,
    input  logic                hv_unlock,
    output logic                permit,
    output logic                id_prot
);
    logic target_locked;

    always_comb begin
        target_locked = prot_bits[op_sector];
        permit        = !target_locked || hv_unlock;
        id_prot       = prot_bits[id_sector];
    end
endmodule

// File: rtl/flash_wp_guard.sv
module flash_wp_guard
    import fwg_pkg::*;
#(
    parameter int NUM_SECT = 8,
    parameter int FILT_CYC = 3,
    localparam int SECT_W  = $clog2(NUM_SECT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ce_n,
    input  logic                we_n,
    input  logic                oe_n,
    input  logic                vcc_ok,
    input  logic                hv_unlock,
    input  logic                op_req,
    input  logic [SECT_W-1:0]   op_sector,
    input  logic [NUM_SECT-1:0] prot_bits,
    input  logic [SECT_W-1:0]   id_sector,
    output logic                wr_strobe,
    output logic                wr_fall,
    output logic                wr_rise,
    output logic                csm_reset,
    output logic                op_grant,
    output logic                op_reject,
    output logic                id_prot
);
    localparam int NSTB = 3;

    logic [NSTB-1:0] raw_stb;
    logic [NSTB-1:0] flt_stb;
    logic            ce_f, we_f, oe_f;
    logic            permit;

    assign raw_stb = {oe_n, we_n, ce_n};

    for (genvar g = 0; g < NSTB; g++) begin : g_flt
        fwg_deglitch #(
            .FILT_CYC (FILT_CYC),
            .IDLE_VAL (1'b1)
        ) u_flt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw_stb[g]),
            .filt_o (flt_stb[g])
        );
    end

    assign ce_f = flt_stb[0];
    assign we_f = flt_stb[1];
    assign oe_f = flt_stb[2];

    fwg_sector_gate #(
        .NUM_SECT (NUM_SECT)
    ) u_gate (
        .prot_bits (prot_bits),
        .op_sector (op_sector),
        .id_sector (id_sector),
        .hv_unlock (hv_unlock),
        .permit    (permit),
        .id_prot   (id_prot)
    );

    guard_state_t st_q, st_d;
    logic         bus_write;

    always_comb begin
        bus_write = !ce_f && !we_f && oe_f;
        st_d      = st_q;
        // power-up inhibit: armed while supply is low, cleared by we high
        if (!vcc_ok)   st_d.inh = 1'b1;
        else if (we_f) st_d.inh = 1'b0;
        st_d.wr      = bus_write && vcc_ok && !st_q.inh;
        st_d.fall    = st_d.wr && !st_q.wr;
        st_d.rise    = st_q.wr && !st_d.wr && vcc_ok;
        st_d.csm_rst = !vcc_ok;
        st_d.grant   = op_req && vcc_ok && permit;
        st_d.reject  = op_req && vcc_ok && !permit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= GUARD_RESET;
        else        st_q <= st_d;
    end

    assign wr_strobe = st_q.wr;
    assign wr_fall   = st_q.fall;
    assign wr_rise   = st_q.rise;
    assign csm_reset = st_q.csm_rst;
    assign op_grant  = st_q.grant;
    assign op_reject = st_q.reject;
endmodule

// File: rtl/fwg_checker.sv
module fwg_checker #(
    parameter int NUM_SECT = 8,
    localparam int SECT_W  = $clog2(NUM_SECT)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                we_n,
    input logic                ce_f,
    input logic                we_f,
    input logic                oe_f,
    input logic                vcc_ok,
    input logic                hv_unlock,
    input logic                op_req,
    input logic [SECT_W-1:0]   op_sector,
    input logic [NUM_SECT-1:0] prot_bits,
    input logic                wr_strobe,
    input logic                wr_fall,
    input logic                wr_rise,
    input logic                csm_reset,
    input logic                op_grant,
    input logic                op_reject
);
    a_r1_strobe_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |-> $past(!ce_f && !we_f && oe_f));

    a_r2_filter_follows_raw: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_f) |-> $past(we_n));

    a_r3_fall_marks_start: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fall |-> (wr_strobe && !$past(wr_strobe)));

    a_r3_rise_marks_end: assert property (@(posedge clk) disable iff (!rst_n)
        wr_rise |-> ($past(wr_strobe) && !wr_strobe));

    a_r4_supply_lockout: assert property (@(posedge clk) disable iff (!rst_n)
        !vcc_ok |=> (!wr_strobe && !wr_rise && csm_reset));

    a_r7_grant_permitted: assert property (@(posedge clk) disable iff (!rst_n)
        op_grant |-> $past(op_req && (!prot_bits[op_sector] || hv_unlock)));

    a_r7_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_grant && op_reject));

    a_r9_no_verdict_low_supply: assert property (@(posedge clk) disable iff (!rst_n)
        !vcc_ok |=> (!op_grant && !op_reject));
endmodule

bind flash_wp_guard fwg_checker #(.NUM_SECT(NUM_SECT)) u_fwg_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_n      (we_n),
    .ce_f      (ce_f),
    .we_f      (we_f),
    .oe_f      (oe_f),
    .vcc_ok    (vcc_ok),
    .hv_unlock (hv_unlock),
    .op_req    (op_req),
    .op_sector (op_sector),
    .prot_bits (prot_bits),
    .wr_strobe (wr_strobe),
    .wr_fall   (wr_fall),
    .wr_rise   (wr_rise),
    .csm_reset (csm_reset),
    .op_grant  (op_grant),
    .op_reject (op_reject)
);

// File: tb/flash_wp_guard_bench.sv
`timescale 1ns/1ps
module flash_wp_guard_bench;
    localparam int NUM_SECT = 8;
    localparam int FILT     = 3;
    localparam int SECT_W   = $clog2(NUM_SECT);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic vcc_ok = 1'b1, hv_unlock = 1'b0, op_req = 1'b0;
    logic [SECT_W-1:0]   op_sector = '0, id_sector = '0;
    logic [NUM_SECT-1:0] prot_bits = 8'b0000_0101;
    logic wr_strobe, wr_fall, wr_rise, csm_reset, op_grant, op_reject, id_prot;

    int checks = 0, fails = 0, fall_cnt = 0, rise_cnt = 0;

    always #4 clk = ~clk;  // 125 MHz

    flash_wp_guard #(.NUM_SECT(NUM_SECT), .FILT_CYC(FILT)) u_flash_wp_guard (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .vcc_ok(vcc_ok), .hv_unlock(hv_unlock), .op_req(op_req),
        .op_sector(op_sector), .prot_bits(prot_bits), .id_sector(id_sector),
        .wr_strobe(wr_strobe), .wr_fall(wr_fall), .wr_rise(wr_rise),
        .csm_reset(csm_reset), .op_grant(op_grant), .op_reject(op_reject),
        .id_prot(id_prot)
    );

    always @(negedge clk) begin
        if (rst_n && wr_fall) fall_cnt++;
        if (rst_n && wr_rise) rise_cnt++;
    end

    // {ce_n, we_n, oe_n, expected wr_strobe}
    localparam logic [3:0] VEC [8] = '{
        4'b0000, 4'b0011, 4'b0100, 4'b0110,
        4'b1000, 4'b1010, 4'b1100, 4'b1110
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    task automatic request(input int sec);
        @(negedge clk);
        op_sector = SECT_W'(sec);
        op_req    = 1'b1;
        @(negedge clk);
        op_req = 1'b0;
        #1;
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int f0, r0;
        tick(3);
        rst_n = 1'b1;
        #1;
        chk("R6 csm_reset after reset", csm_reset, 1);
        chk("R6 wr_strobe after reset", wr_strobe, 0);
        chk("R6 no verdict after reset", op_grant | op_reject, 0);
        tick(FILT + 3);
        chk("R6 csm_reset released", csm_reset, 0);

        // R1 truth table
        for (int v = 0; v < 8; v++) begin
            {ce_n, we_n, oe_n} = VEC[v][3:1];
            tick(FILT + 3);
            chk($sformatf("R1 strobes %03b", VEC[v][3:1]), wr_strobe, VEC[v][0]);
        end
        {ce_n, we_n, oe_n} = 3'b111;
        tick(FILT + 3);

        // R2: short glitch on we_n
        ce_n = 1'b0;
        tick(FILT + 2);
        f0 = fall_cnt; r0 = rise_cnt;
        @(negedge clk); we_n = 1'b0;
        tick(FILT - 1);
        we_n = 1'b1;
        tick(FILT + 3);
        chk("R2 short glitch no write start", fall_cnt - f0, 0);
        chk("R2 short glitch no command", rise_cnt - r0, 0);
        // R2/R3: pulse of exactly the window
        @(negedge clk); we_n = 1'b0;
        tick(FILT - 1);
        @(negedge clk); we_n = 1'b1;
        #1;
        tick(FILT + 3);
        chk("R2 full-width pulse starts write", fall_cnt - f0, 1);
        chk("R3 full-width pulse issues command", rise_cnt - r0, 1);

        // R3 / R4: supply drop during write
        we_n = 1'b0;
        tick(FILT + 3);
        chk("R3 write active", wr_strobe, 1);
        r0 = rise_cnt;
        vcc_ok = 1'b0;
        tick(2);
        chk("R4 strobe cleared on supply low", wr_strobe, 0);
        chk("R4 csm_reset on supply low", csm_reset, 1);
        we_n = 1'b1;
        tick(FILT + 3);
        chk("R4 no command on release during lockout", rise_cnt - r0, 0);

        // R5: write already asserted at power-up
        we_n = 1'b0;
        tick(FILT + 3);
        vcc_ok = 1'b1;
        tick(FILT + 3);
        chk("R5 asserted write blocked at power-up", wr_strobe, 0);
        chk("R5 csm_reset released", csm_reset, 0);
        we_n = 1'b1;
        tick(FILT + 3);
        chk("R5 first we rise not a command", rise_cnt - r0, 0);
        we_n = 1'b0;
        tick(FILT + 3);
        chk("R5 later write accepted", wr_strobe, 1);
        we_n = 1'b1;
        ce_n = 1'b1;
        tick(FILT + 3);

        // R7 / R8: sector permit
        id_sector = 3'd2;
        request(2);
        chk("R7 protected sector rejected", op_reject, 1);
        chk("R7 protected sector not granted", op_grant, 0);
        request(1);
        chk("R7 unprotected sector granted", op_grant, 1);
        hv_unlock = 1'b1;
        request(2);
        chk("R7 override grants protected", op_grant, 1);
        chk("R8 id_prot during override", id_prot, 1);
        hv_unlock = 1'b0;
        request(2);
        chk("R8 protection restored", op_reject, 1);
        chk("R8 id_prot after override", id_prot, 1);
        id_sector = 3'd1;
        #1;
        chk("R8 id_prot unprotected sector", id_prot, 0);

        // R9: request while supply low
        vcc_ok = 1'b0;
        tick(1);
        request(1);
        chk("R9 no grant while supply low", op_grant, 0);
        request(2);
        chk("R9 no reject while supply low", op_reject, 0);
        vcc_ok = 1'b1;
        tick(2);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule